// File: doc/BRIEF.md
# Extended Integer ALU for Legacy Bridge Operations

This block computes a set of older integer operations that a general-purpose integer pipeline may still have to support: absolute value and its negated form, a signed difference that saturates at zero, a mask generator built from two bit indices, and a bit-selected merge of two words. Each operation is issued with one opcode and up to three 32-bit operands. The result, the updated overflow (OV) and summary-overflow (SO) flags, and an optional four-bit condition field appear one clock later.

Operand decoding and register access are done around the block. An immediate form of the saturating difference takes its immediate already sign-extended on the second operand port. The opcodes are `0` absolute, `1` absolute with overflow recording, `2` negated absolute, `3` negated absolute with overflow recording, `4` difference-or-zero, `5` difference-or-zero with overflow recording, `6` immediate difference-or-zero, `7` mask generate and `8` mask merge. The remaining codes are reserved.

Top module: `bridge_alu`

## Requirements
- R1: While reset is asserted, and until the first issued operation, `out_valid`, `result`, `ov_out`, `so_out` and `cr_field` are all zero.
- R2: An operation issued with `in_valid` high produces `out_valid` high one clock later. A cycle with `in_valid` low clears `out_valid` and leaves `result`, `ov_out`, `so_out` and `cr_field` unchanged.
- R3: Absolute value (codes 0 and 1) returns the two's-complement negation of a negative `opnd_a` and returns a non-negative `opnd_a` unchanged. For 0x80000000 the result is 0x80000000. Code 1 then sets OV and SO, and it clears OV for every other input.
- R4: Negated absolute value (codes 2 and 3) negates a strictly positive `opnd_a` and passes zero and negative values through. Code 3 always clears OV.
- R5: Difference-or-zero (codes 4 and 6) returns `opnd_b - opnd_a` when `opnd_b` is greater than `opnd_a` as signed numbers, and zero otherwise. Code 6 treats `opnd_b` as the pre-extended immediate.
- R6: Code 5 returns the same result as code 4. It sets OV and SO when the signed subtraction overflows. It clears OV when there is no overflow and when the result is forced to zero.
- R7: Mask generate (code 7) takes a start index from `opnd_s[4:0]` and an end index from `opnd_b[4:0]`, numbering bits with bit 0 as the MSB. When start is at most end, the result has ones exactly at positions start through end. When start is greater than end, the mask wraps around: ones are at positions from start to 31 and from 0 to end. This gives all ones when start equals end plus one.
- R8: Mask merge (code 8) returns `(opnd_a & ~opnd_b) | (opnd_s & opnd_b)`.
- R9: With `record_en` high, `cr_field[3]`, `[2]` and `[1]` are set when the result is negative, positive and zero respectively, as a signed number, and `cr_field[0]` equals the updated SO. With `record_en` low, `cr_field` is zero.
- R10: Codes 0, 2, 4, 6, 7 and 8 pass `ov_in` and `so_in` to `ov_out` and `so_out` unchanged. Reserved codes do the same and return a zero result. SO is never cleared by the block: `so_in` high always gives `so_out` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, end index or pre-extended immediate |
| opnd_s | input | 32 | Third operand, start index or insert source |
| record_en | input | 1 | Produce the condition field |
| ov_in | input | 1 | Incoming overflow flag |
| so_in | input | 1 | Incoming summary-overflow flag |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Operation result |
| ov_out | output | 1 | Updated overflow flag |
| so_out | output | 1 | Updated summary-overflow flag |
| cr_field | output | 4 | LT, GT, EQ, SO when recording |

## Verification
The embedded assertions check on every cycle that `out_valid` follows `in_valid`, that outputs hold during idle cycles, that SO is never cleared, and that negated absolute value never records overflow. They also check that at most one compare bit is set and that absolute value is non-negative away from the most negative input. Only the bench scenarios can show the exact arithmetic values. These include the signed overflow edges of the saturating difference, the 0x80000000 corner, both ordered and wrapped mask ranges including the all-ones case, and the pass-through of the incoming flags for reserved codes.

// File: rtl/bridge_alu_pkg.sv
package bridge_alu_pkg;
  typedef enum logic [3:0] {
    OP_ABS    = 4'd0,
    OP_ABSO   = 4'd1,
    OP_NABS   = 4'd2,
    OP_NABSO  = 4'd3,
    OP_DOZ    = 4'd4,
    OP_DOZO   = 4'd5,
    OP_DOZI   = 4'd6,
    OP_MASKG  = 4'd7,
    OP_MASKIR = 4'd8
  } alu_op_e;

  function automatic logic op_records_ov(input alu_op_e o);
    return (o == OP_ABSO) || (o == OP_NABSO) || (o == OP_DOZO);
  endfunction
endpackage

// File: rtl/bridge_absdoz_unit.sv
module bridge_absdoz_unit
  import bridge_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic             ov_event
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] neg_a;
  logic [WIDTH-1:0] diff;
  logic             a_neg;
  logic             a_pos;
  logic             b_gt_a;
  logic             sub_ovf;

  always_comb begin
    neg_a   = '0 - a;
    diff    = b - a;
    a_neg   = a[WIDTH-1];
    a_pos   = !a[WIDTH-1] && (a != '0);
    b_gt_a  = $signed(b) > $signed(a);
    sub_ovf = (b[WIDTH-1] ^ a[WIDTH-1]) & (b[WIDTH-1] ^ diff[WIDTH-1]);
  end

  always_comb begin
    res      = '0;
    ov_event = 1'b0;
    unique case (op)
      OP_ABS, OP_ABSO: begin
        res      = a_neg ? neg_a : a;
        ov_event = (a == MOST_NEG);
      end
      OP_NABS, OP_NABSO: begin
        res      = a_pos ? neg_a : a;
        ov_event = 1'b0;
      end
      OP_DOZ, OP_DOZO, OP_DOZI: begin
        res      = b_gt_a ? diff : '0;
        ov_event = b_gt_a && sub_ovf;
      end
      default: begin
        res      = '0;
        ov_event = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bridge_mask_unit.sv
module bridge_mask_unit
  import bridge_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] s,
  output logic [WIDTH-1:0] res
);
  localparam int IDX_W = $clog2(WIDTH);

  logic [IDX_W-1:0] first_idx;
  logic [IDX_W-1:0] last_idx;
  logic [WIDTH-1:0] head_ones;
  logic [WIDTH-1:0] tail_ones;
  logic [WIDTH-1:0] run_mask;
  logic [WIDTH-1:0] gen_mask;
  logic [WIDTH-1:0] merged;

  assign first_idx = s[IDX_W-1:0];
  assign last_idx  = b[IDX_W-1:0];

  // MSB-first numbering: position p is vector bit WIDTH-1-p.
  for (genvar p = 0; p < WIDTH; p++) begin : g_pos
    assign head_ones[WIDTH-1-p] = (IDX_W'(p) >= first_idx);
    assign tail_ones[WIDTH-1-p] = (IDX_W'(p) > last_idx);
  end

  always_comb begin
    run_mask = head_ones ^ tail_ones;
    gen_mask = (first_idx > last_idx) ? ~run_mask : run_mask;
    merged   = (a & ~b) | (s & b);
  end

  always_comb begin
    unique case (op)
      OP_MASKG:  res = gen_mask;
      OP_MASKIR: res = merged;
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/bridge_flag_unit.sv
module bridge_flag_unit
  import bridge_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] res,
  input  logic             ov_event,
  input  logic             ov_in,
  input  logic             so_in,
  input  logic             record_en,
  output logic             ov_nxt,
  output logic             so_nxt,
  output logic [3:0]       cr_nxt
);
  logic writes_ov;
  logic is_zero;

  always_comb begin
    writes_ov = op_records_ov(op);
    ov_nxt    = writes_ov ? ov_event : ov_in;
    so_nxt    = so_in | (writes_ov & ov_event);
    is_zero   = (res == '0);
    if (record_en) begin
      cr_nxt = {res[WIDTH-1], !res[WIDTH-1] && !is_zero, is_zero, so_nxt};
    end else begin
      cr_nxt = 4'b0000;
    end
  end
endmodule

// File: rtl/bridge_alu.sv
module bridge_alu
  import bridge_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [WIDTH-1:0] opnd_s,
  input  logic             record_en,
  input  logic             ov_in,
  input  logic             so_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             ov_out,
  output logic             so_out,
  output logic [3:0]       cr_field
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  // reset: asserted asynchronously, released on the clock
  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic                       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_pipe[RST_SYNC_STAGES-1] & rst_n;

  alu_op_e          op_e;
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] mask_res;
  logic [WIDTH-1:0] res_nxt;
  logic             ov_event;
  logic             ov_nxt;
  logic             so_nxt;
  logic [3:0]       cr_nxt;

  assign op_e = alu_op_e'(op);

  bridge_absdoz_unit #(.WIDTH(WIDTH)) u_absdoz (
    .op(op_e), .a(opnd_a), .b(opnd_b), .res(arith_res), .ov_event(ov_event)
  );

  bridge_mask_unit #(.WIDTH(WIDTH)) u_mask (
    .op(op_e), .a(opnd_a), .b(opnd_b), .s(opnd_s), .res(mask_res)
  );

  assign res_nxt = arith_res | mask_res;

  bridge_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .op(op_e), .res(res_nxt), .ov_event(ov_event), .ov_in(ov_in),
    .so_in(so_in), .record_en(record_en),
    .ov_nxt(ov_nxt), .so_nxt(so_nxt), .cr_nxt(cr_nxt)
  );

  // output registers, enabled by in_valid
  logic             valid_q;
  logic [WIDTH-1:0] result_q;
  logic             ov_q;
  logic             so_q;
  logic [3:0]       cr_q;
  logic             data_en;

  assign data_en = in_valid;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      ov_q     <= 1'b0;
      so_q     <= 1'b0;
      cr_q     <= 4'b0000;
    end else begin
      valid_q <= in_valid;
      if (data_en) begin
        result_q <= res_nxt;
        ov_q     <= ov_nxt;
        so_q     <= so_nxt;
        cr_q     <= cr_nxt;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign ov_out    = ov_q;
  assign so_out    = so_q;
  assign cr_field  = cr_q;

  // R2: one-cycle issue-to-result timing and idle hold
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid |=> out_valid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> (!out_valid && $stable(result) && $stable(so_out) && $stable(cr_field)));
  // R3: absolute value non-negative except the most negative input
  p_abs_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && (op == 4'd0 || op == 4'd1) && opnd_a != MOST_NEG) |=> !result[WIDTH-1]);
  // R4: recorded negated absolute never reports overflow
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && op == 4'd3) |=> !ov_out);
  // R9: at most one compare bit
  p_cr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> $onehot0(cr_field[3:1]));
  // R10: SO is sticky
  p_so_sticky_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && so_in) |=> so_out);
endmodule

// File: tb/sim_bridge_alu.sv
module sim_bridge_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] opnd_a, opnd_b, opnd_s;
  logic        record_en, ov_in, so_in;
  logic        out_valid;
  logic [31:0] result;
  logic        ov_out, so_out;
  logic [3:0]  cr_field;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] exp_res;
  logic        exp_ov, exp_so;
  logic [3:0]  exp_cr;

  bridge_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_s(opnd_s),
    .record_en(record_en), .ov_in(ov_in), .so_in(so_in),
    .out_valid(out_valid), .result(result), .ov_out(ov_out),
    .so_out(so_out), .cr_field(cr_field)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  task automatic model(input logic [3:0] o, input logic [31:0] a, b, s,
                       input logic rec, ovi, soi);
    longint sa, sb, d;
    logic ov_w, ov_e;
    int st, en;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ov_w = 1'b0; ov_e = 1'b0;
    exp_res = 32'h0;
    case (o)
      4'd0, 4'd1: begin
        if (sa < 0) exp_res = 32'(-sa); else exp_res = a;
        ov_w = (o == 4'd1); ov_e = (a == 32'h8000_0000);
      end
      4'd2, 4'd3: begin
        if (sa > 0) exp_res = 32'(-sa); else exp_res = a;
        ov_w = (o == 4'd3); ov_e = 1'b0;
      end
      4'd4, 4'd5, 4'd6: begin
        d = sb - sa;
        if (sb > sa) exp_res = 32'(d); else exp_res = 32'h0;
        ov_w = (o == 4'd5); ov_e = (sb > sa) && (d > 64'sd2147483647);
      end
      4'd7: begin
        st = int'(s[4:0]); en = int'(b[4:0]);
        for (int i = 0; i < 32; i++) begin
          if (st <= en) exp_res[31-i] = (i >= st) && (i <= en);
          else          exp_res[31-i] = (i >= st) || (i <= en);
        end
      end
      4'd8: exp_res = (a & ~b) | (s & b);
      default: exp_res = 32'h0;
    endcase
    exp_ov = ov_w ? ov_e : ovi;
    exp_so = soi | (ov_w & ov_e);
    if (rec) exp_cr = {$signed(exp_res) < 0, $signed(exp_res) > 0, exp_res == 0, exp_so};
    else     exp_cr = 4'b0;
  endtask

  task automatic compare(input string req, input logic exp_valid);
    checks++;
    if (out_valid !== exp_valid || result !== exp_res || ov_out !== exp_ov ||
        so_out !== exp_so || cr_field !== exp_cr) begin
      failures++;
      $display("FAIL %s: got v=%0b res=%08h ov=%0b so=%0b cr=%04b exp v=%0b res=%08h ov=%0b so=%0b cr=%04b",
               req, out_valid, result, ov_out, so_out, cr_field,
               exp_valid, exp_res, exp_ov, exp_so, exp_cr);
    end
  endtask

  task automatic issue(input string req, input logic [3:0] o,
                       input logic [31:0] a, b, s,
                       input logic rec, ovi, soi);
    @(negedge clk);
    in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; opnd_s = s;
    record_en = rec; ov_in = ovi; so_in = soi;
    model(o, a, b, s, rec, ovi, soi);
    @(negedge clk);
    in_valid = 1'b0;
    compare(req, 1'b1);
  endtask

  initial begin
    in_valid = 0; op = 0; opnd_a = 0; opnd_b = 0; opnd_s = 0;
    record_en = 0; ov_in = 0; so_in = 0;
    rst_n = 0;
    exp_res = 0; exp_ov = 0; exp_so = 0; exp_cr = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset state", 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare("R1 after release", 1'b0);

    // R3 absolute value
    issue("R3 abs negative", 4'd0, 32'hFFFF_FFF6, 0, 0, 1, 1, 0);
    issue("R3 abs positive", 4'd0, 32'd77, 0, 0, 0, 1, 0);
    issue("R3 abso most negative", 4'd1, 32'h8000_0000, 0, 0, 1, 0, 0);
    issue("R3 abso clears ov", 4'd1, 32'hFFFF_FF00, 0, 0, 0, 1, 1);
    issue("R3 abs most negative no flag", 4'd0, 32'h8000_0000, 0, 0, 0, 0, 0);
    // R4 negated absolute value
    issue("R4 nabs positive", 4'd2, 32'd5, 0, 0, 1, 0, 0);
    issue("R4 nabs zero", 4'd2, 32'd0, 0, 0, 1, 0, 0);
    issue("R4 nabso clears ov", 4'd3, 32'hFFFF_FFFB, 0, 0, 0, 1, 0);
    // R5 difference-or-zero
    issue("R5 doz b greater", 4'd4, 32'd3, 32'd10, 0, 1, 0, 0);
    issue("R5 doz b smaller", 4'd4, 32'd10, 32'hFFFF_FFFF, 0, 1, 0, 0);
    issue("R5 doz equal", 4'd4, 32'd9, 32'd9, 0, 0, 0, 0);
    issue("R5 dozi immediate", 4'd6, 32'hFFFF_FFF0, 32'hFFFF_FFFE, 0, 1, 0, 0);
    // R6 recorded difference
    issue("R6 dozo overflow", 4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 0, 1, 0, 0);
    issue("R6 dozo no overflow", 4'd5, 32'd1, 32'd4, 0, 0, 1, 0);
    issue("R6 dozo forced zero", 4'd5, 32'd4, 32'd1, 0, 1, 1, 1);
    // R7 mask generate
    issue("R7 maskg run", 4'd7, 0, 32'd7, 32'd4, 0, 0, 0);
    issue("R7 maskg wrap", 4'd7, 0, 32'd3, 32'd28, 0, 0, 0);
    issue("R7 maskg all ones", 4'd7, 0, 32'd9, 32'd10, 1, 0, 0);
    issue("R7 maskg single bit 31", 4'd7, 0, 32'hFFFF_FFFF, 32'h0000_001F, 0, 0, 0);
    issue("R7 maskg full range", 4'd7, 0, 32'd31, 32'd0, 0, 0, 0);
    // R8 mask merge
    issue("R8 maskir", 4'd8, 32'hAAAA_5555, 32'h00FF_FF00, 32'h1234_5678, 1, 0, 1);
    // R10 pass-through and reserved
    issue("R10 reserved code", 4'd12, 32'd1, 32'd2, 32'd3, 1, 1, 1);
    issue("R10 doz keeps flags", 4'd4, 32'd1, 32'd2, 0, 0, 1, 1);

    // R2 idle hold: no issue, outputs keep their values
    @(negedge clk);
    opnd_a = 32'h1357_9BDF; op = 4'd8; ov_in = 0; so_in = 0; record_en = 1;
    @(negedge clk);
    compare("R2 idle hold", 1'b0);

    // mixed scenarios, R9 compare bits included
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra, rb, rs;
      logic [3:0] ro;
      ra = $urandom(); rb = $urandom(); rs = $urandom();
      if (k % 5 == 0) ra = 32'h8000_0000;
      if (k % 7 == 0) rb = 32'h7FFF_FFFF;
      ro = 4'($urandom_range(0, 9));
      issue("R9 mixed", ro, ra, rb, rs, 1'($urandom()), 1'($urandom()), 1'($urandom()));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule